// File: doc/BRIEF.md
# Debug Scan-Chain Register Access Unit

This block sits behind a JTAG test access port and lets an external debugger read and write a bank of up to 32 on-chip debug register slots. The debugger moves a 38-bit frame through the chain on each scan. The frame holds a data word, a slot address and a direction flag. Every flop in the block runs on the test clock. The TAP state machine and instruction decode sit outside the block and provide level signals that mark the Capture-DR, Shift-DR and Update-DR states. A chain-select input qualifies all three.

A write takes one scan. When the frame reaches Update-DR with the flag set, the block pulses a one-hot write strobe for the addressed slot. The data word goes out alongside it, cut down to that slot's width. A read takes two scans. The first scan's Update-DR selects a slot. The next scan's Capture-DR loads that slot's value into the data field and pulses a read strobe for the slot, so registers with read side effects can consume an entry. The block holds the debug control slot itself, so its monitor-mode enable can be read back. All other slots are supplied from outside through a flat read bus.

Top module: `dbg_scan_access`

## Requirements
- R1: The 38-bit shift register moves one bit per Shift-DR cycle, least significant bit first, from `tdi` toward `tdo`. `tdo` is shift-register bit 0. A frame shifted in appears unchanged at `tdo` during the next 38 shift cycles.
- R2: At Update-DR with frame bit 37 = 1 and a mapped slot in bits 36:32, the block asserts `wr_stb` for that slot only, for that cycle only. `wr_data` carries frame bits 31:0.
- R3: At Update-DR with frame bit 37 = 0, the selected slot becomes frame bits 36:32. No write strobe is produced. Nothing else changes the selected slot.
- R4: At Capture-DR the block loads the selected slot's value into frame bits 31:0, the selected address into bits 36:32, and 0 into bit 37. In the same cycle it asserts `rd_stb` for that slot only.
- R5: Unmapped slots read as zero and get no read strobe. A write to an unmapped slot produces no write strobe. Mapped slots are 0, 1, 2, 4, 5, 8 to 13 and 16 to 21.
- R6: Read values and `wr_data` keep only the low bits of each slot's width. The widths are: slot 0 is 6 bits, slot 1 is 5, slot 2 is 8, slot 4 is 6, slot 5 is 32, slots 8 to 11 and 16 to 19 are 32, slots 12 and 20 are 9, and slots 13 and 21 are 8.
- R7: A slot stays selected across scans. Every further Capture-DR reads it again and asserts its read strobe again.
- R8: After TAP reset, slot 4 is selected, the shift register is all zero (`tdo` = 0), and the debug control value is zero.
- R9: The block stores slot 0 (6-bit debug control) internally and writes it at R2 writes to slot 0. `dbg_ctrl` shows it. `mon_en` is its bit 4, and it reads back through R4.
- R10: While `chain_sel` is low, capture, shift and update have no effect. No strobes are produced, and the shift register, selected slot and debug control are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | TAP reset, active low, asynchronous |
| chain_sel | input | 1 | This chain is the selected data register |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (shift-register bit 0) |
| wr_stb | output | 32 | One-hot write strobe per slot |
| wr_data | output | 32 | Write data, cut to the slot width |
| rd_stb | output | 32 | One-hot read strobe per slot at capture |
| rd_bus | input | 992 | Read values of slots 1 to 31, slot k at bits 32k-1 down to 32(k-1) |
| dbg_ctrl | output | 6 | Stored debug control value |
| mon_en | output | 1 | Monitor-mode enable, bit 4 of debug control |

## Verification
Write and read strobes are combinational in the Update-DR and Capture-DR cycles. The bench samples them 1 ns after the negative edge that enters those states, before the rising edge that ends them. Read data is captured at that rising edge, so it comes out at `tdo` over the next 38 shift cycles of the same scan. Each bit is sampled after its negative edge and before its rising edge. Because a read is pipelined, a selection made in scan N is only checked against the data returned in scan N+1. The debug control port is checked once the update edge has passed.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 5;
    localparam int FRAME_W     = DATA_W + ADDR_W + 1;
    localparam int NSLOT       = 1 << ADDR_W;

    localparam int CTRL_SLOT   = 0;
    localparam int CTRL_W      = 6;
    localparam int MON_BIT     = 4;
    localparam int RESET_SEL   = 4;

    localparam int WATCH_BASE  = 8;
    localparam int WATCH_PITCH = 8;
    localparam int WATCH_UNITS = 2;
    localparam int WATCH_REGS  = 6;

    // Implemented width of a slot; zero marks an unmapped slot.
    function automatic int unsigned slot_bits(int unsigned a);
        int unsigned rel;
        int unsigned w;
        w = 0;
        case (a)
            0: w = CTRL_W;
            1: w = 5;
            2: w = 8;
            4: w = 6;
            5: w = 32;
            default: begin
                if (a >= WATCH_BASE) begin
                    rel = a - WATCH_BASE;
                    if ((rel / WATCH_PITCH) < WATCH_UNITS &&
                        (rel % WATCH_PITCH) < WATCH_REGS) begin
                        case (rel % WATCH_PITCH)
                            4:       w = 9;
                            5:       w = 8;
                            default: w = 32;
                        endcase
                    end
                end
            end
        endcase
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] slot_mask(int unsigned a);
        int unsigned w;
        logic [DATA_W-1:0] one;
        w   = slot_bits(a);
        one = 1;
        if (w >= DATA_W) return '1;
        return (one << w) - one;
    endfunction

endpackage

// File: rtl/dbg_scan_shifter.sv
module dbg_scan_shifter
    import dbg_scan_pkg::*;
#(
    parameter int LEN = FRAME_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_en,
    input  logic           shift_en,
    input  logic [LEN-1:0] cap_word,
    input  logic           tdi,
    output logic [LEN-1:0] frame_q,
    output logic           tdo
);

    typedef struct packed {
        logic [LEN-1:0] frame;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (cap_en) begin
            sh_d.frame = cap_word;
        end else if (shift_en) begin
            sh_d.frame = {tdi, sh_q.frame[LEN-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign frame_q = sh_q.frame;
    assign tdo     = sh_q.frame[0];

    p_shift_lsb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !cap_en) |=>
            (frame_q[LEN-2:0] == $past(frame_q[LEN-1:1])) && (frame_q[LEN-1] == $past(tdi)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !cap_en) |=> $stable(frame_q));

    p_capture_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> frame_q == $past(cap_word));

endmodule

// File: rtl/dbg_slot_decode.sv
module dbg_slot_decode
    import dbg_scan_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NS = NSLOT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [AW-1:0] addr,
    output logic [NS-1:0] stb
);

    for (genvar i = 0; i < NS; i++) begin : g_slot
        if (slot_bits(i) != 0) begin : g_live
            assign stb[i] = fire && (addr == AW'(i));
        end else begin : g_dead
            assign stb[i] = 1'b0;
        end
    end

    p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));

    p_unmapped_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_bits(addr) == 0) |-> (stb == '0));

    p_mapped_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && slot_bits(addr) != 0) |-> ($countones(stb) == 1 && stb[addr]));

endmodule

// File: rtl/dbg_read_mux.sv
module dbg_read_mux
    import dbg_scan_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NS = NSLOT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        sel,
    input  logic [DW-1:0]        ctrl_word,
    input  logic [(NS-1)*DW-1:0] ext_bus,
    output logic [DW-1:0]        word
);

    logic [DW-1:0] masked [NS];

    for (genvar i = 0; i < NS; i++) begin : g_src
        if (i == CTRL_SLOT) begin : g_own
            assign masked[i] = ctrl_word & slot_mask(i);
        end else if (i < CTRL_SLOT) begin : g_lo
            assign masked[i] = ext_bus[i*DW +: DW] & slot_mask(i);
        end else begin : g_hi
            assign masked[i] = ext_bus[(i-1)*DW +: DW] & slot_mask(i);
        end
    end

    assign word = masked[sel];

    p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_bits(sel) == 0) |-> (word == '0));

    p_width_trim_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word & ~slot_mask(sel)) == '0);

endmodule

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
    import dbg_scan_pkg::*;
#(
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_val,
    output logic [CW-1:0] ctrl_q
);

    typedef struct packed {
        logic [CW-1:0] val;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) ctl_d.val = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctrl_q = ctl_q.val;

    p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));

    p_ctrl_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctrl_q == $past(wr_val));

endmodule

// File: rtl/dbg_scan_access.sv
module dbg_scan_access
    import dbg_scan_pkg::*;
(
    input  logic                         tck,
    input  logic                         trst_n,
    input  logic                         chain_sel,
    input  logic                         capture_dr,
    input  logic                         shift_dr,
    input  logic                         update_dr,
    input  logic                         tdi,
    output logic                         tdo,
    output logic [NSLOT-1:0]             wr_stb,
    output logic [DATA_W-1:0]            wr_data,
    output logic [NSLOT-1:0]             rd_stb,
    input  logic [(NSLOT-1)*DATA_W-1:0]  rd_bus,
    output logic [CTRL_W-1:0]            dbg_ctrl,
    output logic                         mon_en
);

    localparam int FLAG_BIT = FRAME_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] sel;
    } acc_t;

    acc_t st_d, st_q;

    logic                cap_en;
    logic                shift_en;
    logic                upd_fire;
    logic [FRAME_W-1:0]  frame_q;
    logic [FRAME_W-1:0]  cap_word;
    logic [DATA_W-1:0]   f_data;
    logic [ADDR_W-1:0]   f_addr;
    logic                f_write;
    logic [DATA_W-1:0]   rd_word;
    logic [CTRL_W-1:0]   ctrl_q;

    // TAP states are exclusive; capture wins, then shift, then update.
    assign cap_en   = chain_sel && capture_dr;
    assign shift_en = chain_sel && shift_dr && !capture_dr;
    assign upd_fire = chain_sel && update_dr && !capture_dr && !shift_dr;

    assign f_data  = frame_q[DATA_W-1:0];
    assign f_addr  = frame_q[DATA_W +: ADDR_W];
    assign f_write = frame_q[FLAG_BIT];

    always_comb begin
        st_d = st_q;
        if (upd_fire && !f_write) st_d.sel = f_addr;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= '{sel: ADDR_W'(RESET_SEL)};
        else         st_q <= st_d;
    end

    always_comb begin
        wr_data = f_data & slot_mask(f_addr);
    end

    assign cap_word = {1'b0, st_q.sel, rd_word};

    dbg_scan_shifter #(.LEN(FRAME_W)) u_shift (
        .clk      (tck),
        .rst_n    (trst_n),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .cap_word (cap_word),
        .tdi      (tdi),
        .frame_q  (frame_q),
        .tdo      (tdo)
    );

    dbg_slot_decode #(.AW(ADDR_W), .NS(NSLOT)) u_wr_dec (
        .clk   (tck),
        .rst_n (trst_n),
        .fire  (upd_fire && f_write),
        .addr  (f_addr),
        .stb   (wr_stb)
    );

    dbg_slot_decode #(.AW(ADDR_W), .NS(NSLOT)) u_rd_dec (
        .clk   (tck),
        .rst_n (trst_n),
        .fire  (cap_en),
        .addr  (st_q.sel),
        .stb   (rd_stb)
    );

    dbg_read_mux #(.DW(DATA_W), .AW(ADDR_W), .NS(NSLOT)) u_rd_mux (
        .clk       (tck),
        .rst_n     (trst_n),
        .sel       (st_q.sel),
        .ctrl_word (DATA_W'(ctrl_q)),
        .ext_bus   (rd_bus),
        .word      (rd_word)
    );

    dbg_ctrl_reg #(.CW(CTRL_W)) u_ctrl (
        .clk    (tck),
        .rst_n  (trst_n),
        .wr_en  (wr_stb[CTRL_SLOT]),
        .wr_val (wr_data[CTRL_W-1:0]),
        .ctrl_q (ctrl_q)
    );

    assign dbg_ctrl = ctrl_q;
    assign mon_en   = ctrl_q[MON_BIT];

    p_sel_load_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (upd_fire && !f_write) |=> st_q.sel == $past(f_addr));

    p_sel_hold_r7: assert property (@(posedge tck) disable iff (!trst_n)
        !(upd_fire && !f_write) |=> $stable(st_q.sel));

    p_unselected_quiet_r10: assert property (@(posedge tck) disable iff (!trst_n)
        !chain_sel |-> (wr_stb == '0 && rd_stb == '0));

    p_read_no_write_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (update_dr && !f_write) |-> wr_stb == '0);

endmodule

// File: tb/dbg_scan_access_test.sv
module dbg_scan_access_test;
    import dbg_scan_pkg::*;

    logic                        tck = 1'b0;
    logic                        trst_n = 1'b0;
    logic                        chain_sel = 1'b0;
    logic                        capture_dr = 1'b0;
    logic                        shift_dr = 1'b0;
    logic                        update_dr = 1'b0;
    logic                        tdi = 1'b0;
    logic                        tdo;
    logic [31:0]                 wr_stb;
    logic [31:0]                 wr_data;
    logic [31:0]                 rd_stb;
    logic [31*32-1:0]            rd_bus;
    logic [5:0]                  dbg_ctrl;
    logic                        mon_en;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd_seen;
    logic [31:0] wr_seen;
    logic [31:0] wd_seen;

    always #5 tck = ~tck;

    dbg_scan_access uut (
        .tck(tck), .trst_n(trst_n), .chain_sel(chain_sel),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_bus(rd_bus), .dbg_ctrl(dbg_ctrl), .mon_en(mon_en)
    );

    // {write, mapped, addr, data, expected}
    typedef struct packed {
        logic        wr;
        logic        live;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        {1'b1, 1'b1, 5'd12, 32'hFFFF_FFFF, 32'h0000_01FF},
        {1'b1, 1'b1, 5'd13, 32'hFFFF_FFFF, 32'h0000_00FF},
        {1'b1, 1'b1, 5'd4,  32'h0000_00FF, 32'h0000_003F},
        {1'b1, 1'b1, 5'd9,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {1'b1, 1'b0, 5'd7,  32'hFFFF_FFFF, 32'h0000_0000},
        {1'b1, 1'b1, 5'd0,  32'h0000_0010, 32'h0000_0010},
        {1'b0, 1'b1, 5'd1,  32'h0,         32'h0000_001F},
        {1'b0, 1'b1, 5'd2,  32'h0,         32'h0000_00FF},
        {1'b0, 1'b1, 5'd8,  32'h0,         32'h1234_5678},
        {1'b0, 1'b1, 5'd20, 32'h0,         32'h0000_01FF},
        {1'b0, 1'b0, 5'd31, 32'h0,         32'h0000_0000},
        {1'b0, 1'b0, 5'd3,  32'h0,         32'h0000_0000},
        {1'b0, 1'b1, 5'd0,  32'h0,         32'h0000_0010}
    };

    function automatic logic [37:0] mkf(logic w, logic [4:0] a, logic [31:0] d);
        return {w, a, d};
    endfunction

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // One DR pass: optional capture, 38 shifts, optional update.
    task automatic run_scan(input logic sel, input logic do_cap, input logic do_upd,
                            input logic [37:0] fin, output logic [37:0] fout);
        rd_seen = '0;
        wr_seen = '0;
        wd_seen = '0;
        @(negedge tck);
        chain_sel = sel;
        if (do_cap) begin
            capture_dr = 1'b1;
            #1 rd_seen = rd_stb;
            @(negedge tck);
            capture_dr = 1'b0;
        end
        for (int i = 0; i < 38; i++) begin
            shift_dr = 1'b1;
            tdi = fin[i];
            #1 fout[i] = tdo;
            @(negedge tck);
        end
        shift_dr = 1'b0;
        tdi = 1'b0;
        if (do_upd) begin
            update_dr = 1'b1;
            #1 begin
                wr_seen = wr_stb;
                wd_seen = wr_data;
            end
            @(negedge tck);
            update_dr = 1'b0;
        end
        chain_sel = 1'b0;
    endtask

    initial begin
        rd_bus = '1;
        rd_bus[7*32 +: 32] = 32'h1234_5678;   // slot 8
    end

    initial begin : watchdog
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [37:0] fo;
        logic [37:0] junk;

        repeat (3) @(negedge tck);
        // R8: reset state
        chk("R8", "tdo after reset", 64'(tdo), 64'h0);
        chk("R8", "dbg_ctrl after reset", 64'(dbg_ctrl), 64'h0);
        chk("R8", "mon_en after reset", 64'(mon_en), 64'h0);
        trst_n = 1'b1;

        // R8/R4: first capture returns reset selection (slot 4, 6 bits)
        run_scan(1'b1, 1'b1, 1'b0, 38'h0, fo);
        chk("R8", "reset-selected read strobe", 64'(rd_seen), 64'(32'h1 << 4));
        chk("R4", "captured data slot 4", 64'(fo[31:0]), 64'h3F);
        chk("R4", "captured addr field", 64'(fo[36:32]), 64'd4);
        chk("R4", "captured flag bit", 64'(fo[37]), 64'h0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) begin
                run_scan(1'b1, 1'b0, 1'b1, mkf(1'b1, VECS[v].addr, VECS[v].data), junk);
                if (VECS[v].live) begin
                    chk("R2", "write strobe", 64'(wr_seen), 64'(32'h1 << VECS[v].addr));
                    chk("R6", "write data trimmed", 64'(wd_seen), 64'(VECS[v].exp));
                end else begin
                    chk("R5", "unmapped write strobe", 64'(wr_seen), 64'h0);
                end
            end else begin
                run_scan(1'b1, 1'b0, 1'b1, mkf(1'b0, VECS[v].addr, 32'hFFFF_FFFF), junk);
                chk("R3", "no write strobe on select", 64'(wr_seen), 64'h0);
                run_scan(1'b1, 1'b1, 1'b1, mkf(1'b0, 5'd4, 32'h0), fo);
                chk("R6", "read data trimmed", 64'(fo[31:0]), 64'(VECS[v].exp));
                chk("R4", "read addr field", 64'(fo[36:32]), 64'(VECS[v].addr));
                chk(VECS[v].live ? "R4" : "R5", "read strobe",
                    64'(rd_seen), VECS[v].live ? 64'(32'h1 << VECS[v].addr) : 64'h0);
            end
        end

        // R9: monitor enable follows bit 4 of stored control
        chk("R9", "mon_en after ctrl write", 64'(mon_en), 64'h1);
        chk("R9", "dbg_ctrl value", 64'(dbg_ctrl), 64'h10);
        run_scan(1'b1, 1'b0, 1'b1, mkf(1'b1, 5'd0, 32'hFFFF_FFEF), junk);
        chk("R9", "dbg_ctrl trimmed write", 64'(dbg_ctrl), 64'h2F);
        chk("R9", "mon_en cleared", 64'(mon_en), 64'h0);

        // R7: repeated capture of a held selection
        run_scan(1'b1, 1'b0, 1'b1, mkf(1'b0, 5'd5, 32'h0), junk);
        run_scan(1'b1, 1'b1, 1'b0, 38'h0, fo);
        chk("R7", "first repeat strobe", 64'(rd_seen), 64'(32'h1 << 5));
        chk("R7", "first repeat data", 64'(fo[31:0]), 64'hFFFF_FFFF);
        run_scan(1'b1, 1'b1, 1'b1, mkf(1'b1, 5'd9, 32'h0), fo);
        chk("R7", "second repeat strobe", 64'(rd_seen), 64'(32'h1 << 5));
        run_scan(1'b1, 1'b1, 1'b0, 38'h0, fo);
        chk("R7", "write keeps selection", 64'(fo[36:32]), 64'd5);

        // R1: pass-through of a shifted frame
        run_scan(1'b1, 1'b0, 1'b0, 38'h2A_5A5A_C3C3, junk);
        run_scan(1'b1, 1'b0, 1'b0, 38'h0, fo);
        chk("R1", "shifted frame out", 64'(fo), 64'h2A_5A5A_C3C3);

        // R10: chain not selected
        run_scan(1'b1, 1'b0, 1'b0, 38'h15_0F0F_1234, junk);
        run_scan(1'b0, 1'b1, 1'b1, mkf(1'b1, 5'd0, 32'h3F), junk);
        chk("R10", "read strobe when idle", 64'(rd_seen), 64'h0);
        chk("R10", "write strobe when idle", 64'(wr_seen), 64'h0);
        chk("R10", "dbg_ctrl unchanged", 64'(dbg_ctrl), 64'h2F);
        run_scan(1'b1, 1'b0, 1'b0, 38'h0, fo);
        chk("R10", "shift register unchanged", 64'(fo), 64'h15_0F0F_1234);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule